// File: doc/BRIEF.md
# RGMII Lane Control Codec

This block sits between a byte-wide MAC datapath and the logical view of a reduced gigabit PHY link. That link has four data lines and one control line in each direction. Each link clock is modelled as one cycle of `clk`. The value on the rising edge and the value on the falling edge appear as two separate ports.

On the transmit side, a byte arrives with an enable flag and an error flag. The block turns it into rising-phase and falling-phase nibbles and two control bits. On the control line, the rising phase carries the enable and the falling phase carries enable XOR error. The receive side does the reverse. It rebuilds bytes, recovers data valid, and recovers the error as the XOR of the two control phases. It also reports the control pattern that means "error with no data" as a separate out-of-band event, together with the nibble that came with it.

A mode input selects the rate:
- **Gigabit mode:** both edges carry data, so a full byte moves every clock.
- **10/100 mode:** only the rising edge carries data. Each byte takes two consecutive clocks, low nibble first, and the falling-phase data copies the rising-phase data.

The control-line encoding is the same in both modes. There are no carrier-sense or collision signals.

Top module: `rgmii_lane_codec`

## Requirements
- R1: In gigabit mode (`gigMode`=1), `txReady` is always 1. A byte presented at a clock edge appears on the outputs after that edge: bits [3:0] on `txRiseData` and bits [7:4] on `txFallData`.
- R2: A byte accepted with `txReady`=1 produces, after that edge, `txRiseCtl` = `txEn` and `txFallCtl` = `txEn` XOR `txErr`. This holds in both modes.
- R3: In 10/100 mode (`gigMode`=0), each byte takes two clocks, and `txReady` is 1 only on the first.
  - After the accepting edge, both `txRiseData` and `txFallData` show bits [3:0].
  - After the next edge, both show bits [7:4].
  - Inputs presented while `txReady`=0 are ignored.
- R4: In 10/100 mode, both control bits of the second clock of a byte equal those of the first clock.
- R5: In gigabit mode, a clock with `rxRiseCtl`=1 produces, after that edge, `rxByteValid`=1 and `rxByte` = {`rxFallData`, `rxRiseData`}.
- R6: `rxErr` is 1 only together with `rxByteValid`. It equals `rxRiseCtl` XOR `rxFallCtl` of the clock (or clocks) that built the byte.
- R7: In 10/100 mode, two consecutive clocks with `rxRiseCtl`=1 build one byte.
  - The first clock's `rxRiseData` becomes bits [3:0] and the second clock's becomes bits [7:4]. `rxFallData` is ignored.
  - `rxByteValid` pulses only after the second edge.
  - `rxErr` is the OR of the two clocks' control XOR.
- R8: In 10/100 mode, a clock with `rxRiseCtl`=0 drops any half-built byte. The next clock with `rxRiseCtl`=1 starts a new byte.
- R9: A clock with `rxRiseCtl`=0 and `rxFallCtl`=1 produces, after that edge, an `rxOob` pulse with `rxOobCode` = `rxRiseData`, and no byte strobe.
- R10: A clock with both receive control bits at 0 (idle) produces no byte strobe, no error and no out-of-band pulse.
- R11: During and right after reset, all transmit and receive outputs are 0 and `txReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one cycle per interface clock |
| rst | input | 1 | Synchronous reset, active high |
| gigMode | input | 1 | 1 selects gigabit (both edges); 0 selects 10/100 (rising edge only) |
| txByte | input | 8 | Byte to transmit |
| txEn | input | 1 | Transmit enable for `txByte` |
| txErr | input | 1 | Transmit error for `txByte` |
| txReady | output | 1 | `txByte`, `txEn` and `txErr` are taken at this edge |
| txRiseData | output | 4 | Transmit data, rising phase |
| txFallData | output | 4 | Transmit data, falling phase |
| txRiseCtl | output | 1 | Transmit control, rising phase |
| txFallCtl | output | 1 | Transmit control, falling phase |
| rxRiseData | input | 4 | Receive data, rising phase |
| rxFallData | input | 4 | Receive data, falling phase |
| rxRiseCtl | input | 1 | Receive control, rising phase |
| rxFallCtl | input | 1 | Receive control, falling phase |
| rxByte | output | 8 | Rebuilt receive byte |
| rxByteValid | output | 1 | One-cycle strobe for `rxByte` |
| rxErr | output | 1 | Error flag for the strobed byte |
| rxOob | output | 1 | One-cycle strobe for an error-without-data event |
| rxOobCode | output | 4 | Nibble that came with the out-of-band event |

## Verification
The bench builds the block with its default four-bit nibble, so a byte has only 256 values. Every transmit byte is therefore swept in both modes under all four enable/error combinations. Every receive byte is swept in both modes with both falling-phase control values. In 10/100 mode, the error is placed on the first clock, the second clock, both, or neither.

With the nibble this small, all sixteen out-of-band codes and all idle codes can be checked too. Beyond the sweeps, the bench checks that junk presented on the second transmit clock is ignored. It also checks that a lone rising-control clock followed by idle does not corrupt the next received byte.

// File: rtl/rgmii_lane_pkg.sv
package rgmii_lane_pkg;
  typedef struct packed {
    logic txLoad;    // take a new byte at this edge
    logic txSecond;  // 10/100: drive the held high nibble
    logic rxFirst;   // 10/100: capture low nibble
    logic rxEmit;    // complete byte at this edge
  } laneStrobes_t;
endpackage

// File: rtl/rgmii_lane_ctrl.sv
module rgmii_lane_ctrl
  import rgmii_lane_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         gigMode,
  input  logic         rxRiseCtl,
  output logic         txReady,
  output laneStrobes_t strobes
);
  logic txPhase;
  logic rxPhase;

  always_ff @(posedge clk) begin
    if (rst || gigMode) begin
      txPhase <= 1'b0;
    end else begin
      txPhase <= ~txPhase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || gigMode || !rxRiseCtl) begin
      rxPhase <= 1'b0;
    end else begin
      rxPhase <= ~rxPhase;
    end
  end

  always_comb begin
    txReady          = gigMode || !txPhase;
    strobes.txLoad   = txReady;
    strobes.txSecond = !gigMode && txPhase;
    strobes.rxFirst  = !gigMode && rxRiseCtl && !rxPhase;
    strobes.rxEmit   = rxRiseCtl && (gigMode || rxPhase);
  end
endmodule

// File: rtl/rgmii_lane_dp.sv
module rgmii_lane_dp
  import rgmii_lane_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gigMode,
  input  laneStrobes_t        strobes,
  input  logic [BYTE_W-1:0]   txByte,
  input  logic                txEn,
  input  logic                txErr,
  output logic [NIBBLE_W-1:0] txRiseData,
  output logic [NIBBLE_W-1:0] txFallData,
  output logic                txRiseCtl,
  output logic                txFallCtl,
  input  logic [NIBBLE_W-1:0] rxRiseData,
  input  logic [NIBBLE_W-1:0] rxFallData,
  input  logic                rxRiseCtl,
  input  logic                rxFallCtl,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                rxByteValid,
  output logic                rxErr,
  output logic                rxOob,
  output logic [NIBBLE_W-1:0] rxOobCode
);
  logic [NIBBLE_W-1:0] txHoldHigh;
  logic [NIBBLE_W-1:0] rxHoldLow;
  logic                rxHoldErr;
  logic [NIBBLE_W-1:0] txLow;
  logic [NIBBLE_W-1:0] txHigh;
  logic                rxPhaseErr;

  assign txLow      = txByte[NIBBLE_W-1:0];
  assign txHigh     = txByte[BYTE_W-1:NIBBLE_W];
  assign rxPhaseErr = rxRiseCtl ^ rxFallCtl;

  // transmit path
  always_ff @(posedge clk) begin
    if (rst) begin
      txRiseData <= '0;
      txFallData <= '0;
      txRiseCtl  <= 1'b0;
      txFallCtl  <= 1'b0;
      txHoldHigh <= '0;
    end else if (strobes.txLoad) begin
      txRiseData <= txLow;
      txFallData <= gigMode ? txHigh : txLow;
      txRiseCtl  <= txEn;
      txFallCtl  <= txEn ^ txErr;
      txHoldHigh <= txHigh;
    end else if (strobes.txSecond) begin
      txRiseData <= txHoldHigh;
      txFallData <= txHoldHigh;
    end
  end

  // receive path
  always_ff @(posedge clk) begin
    if (rst) begin
      rxHoldLow   <= '0;
      rxHoldErr   <= 1'b0;
      rxByte      <= '0;
      rxByteValid <= 1'b0;
      rxErr       <= 1'b0;
      rxOob       <= 1'b0;
      rxOobCode   <= '0;
    end else begin
      if (strobes.rxFirst) begin
        rxHoldLow <= rxRiseData;
        rxHoldErr <= rxPhaseErr;
      end
      rxByteValid <= strobes.rxEmit;
      if (strobes.rxEmit) begin
        rxByte <= gigMode ? {rxFallData, rxRiseData} : {rxRiseData, rxHoldLow};
        rxErr  <= gigMode ? rxPhaseErr : (rxPhaseErr | rxHoldErr);
      end else begin
        rxErr  <= 1'b0;
      end
      rxOob <= !rxRiseCtl && rxFallCtl;
      if (!rxRiseCtl && rxFallCtl) begin
        rxOobCode <= rxRiseData;
      end
    end
  end
endmodule

// File: rtl/rgmii_lane_codec.sv
module rgmii_lane_codec
  import rgmii_lane_pkg::*;
#(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gigMode,
  input  logic [BYTE_W-1:0]   txByte,
  input  logic                txEn,
  input  logic                txErr,
  output logic                txReady,
  output logic [NIBBLE_W-1:0] txRiseData,
  output logic [NIBBLE_W-1:0] txFallData,
  output logic                txRiseCtl,
  output logic                txFallCtl,
  input  logic [NIBBLE_W-1:0] rxRiseData,
  input  logic [NIBBLE_W-1:0] rxFallData,
  input  logic                rxRiseCtl,
  input  logic                rxFallCtl,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                rxByteValid,
  output logic                rxErr,
  output logic                rxOob,
  output logic [NIBBLE_W-1:0] rxOobCode
);
  laneStrobes_t strobes;

  rgmii_lane_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .gigMode   (gigMode),
    .rxRiseCtl (rxRiseCtl),
    .txReady   (txReady),
    .strobes   (strobes)
  );

  rgmii_lane_dp #(.NIBBLE_W(NIBBLE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .gigMode     (gigMode),
    .strobes     (strobes),
    .txByte      (txByte),
    .txEn        (txEn),
    .txErr       (txErr),
    .txRiseData  (txRiseData),
    .txFallData  (txFallData),
    .txRiseCtl   (txRiseCtl),
    .txFallCtl   (txFallCtl),
    .rxRiseData  (rxRiseData),
    .rxFallData  (rxFallData),
    .rxRiseCtl   (rxRiseCtl),
    .rxFallCtl   (rxFallCtl),
    .rxByte      (rxByte),
    .rxByteValid (rxByteValid),
    .rxErr       (rxErr),
    .rxOob       (rxOob),
    .rxOobCode   (rxOobCode)
  );
endmodule

// File: rtl/rgmii_lane_codec_chk.sv
module rgmii_lane_codec_chk #(
  parameter int NIBBLE_W = 4,
  localparam int BYTE_W = 2 * NIBBLE_W
) (
  input logic                clk,
  input logic                rst,
  input logic                gigMode,
  input logic [BYTE_W-1:0]   txByte,
  input logic                txEn,
  input logic                txErr,
  input logic                txReady,
  input logic [NIBBLE_W-1:0] txRiseData,
  input logic [NIBBLE_W-1:0] txFallData,
  input logic                txRiseCtl,
  input logic                txFallCtl,
  input logic                rxRiseCtl,
  input logic                rxFallCtl,
  input logic                rxByteValid,
  input logic                rxErr,
  input logic                rxOob
);
  assert_gig_ready_R1: assert property (@(posedge clk) disable iff (rst)
    gigMode |-> txReady);

  assert_gig_split_R1: assert property (@(posedge clk) disable iff (rst)
    (gigMode && txReady) |=> (txRiseData == $past(txByte[NIBBLE_W-1:0]) &&
                              txFallData == $past(txByte[BYTE_W-1:NIBBLE_W])));

  assert_tx_ctl_enc_R2: assert property (@(posedge clk) disable iff (rst)
    txReady |=> (txRiseCtl == $past(txEn) && (txRiseCtl ^ txFallCtl) == $past(txErr)));

  assert_slow_dup_R3: assert property (@(posedge clk) disable iff (rst)
    !gigMode |=> (txRiseData == txFallData));

  assert_slow_ready_alt_R3: assert property (@(posedge clk) disable iff (rst)
    (!gigMode && txReady) |=> (gigMode || !txReady));

  assert_slow_ctl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!gigMode && !txReady) |=> ($stable(txRiseCtl) && $stable(txFallCtl)));

  assert_gig_rx_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (gigMode && rxRiseCtl) |=> rxByteValid);

  assert_err_with_byte_R6: assert property (@(posedge clk) disable iff (rst)
    rxErr |-> rxByteValid);

  assert_oob_detect_R9: assert property (@(posedge clk) disable iff (rst)
    (!rxRiseCtl && rxFallCtl) |=> (rxOob && !rxByteValid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!rxRiseCtl && !rxFallCtl) |=> (!rxOob && !rxByteValid && !rxErr));
endmodule

bind rgmii_lane_codec rgmii_lane_codec_chk #(.NIBBLE_W(NIBBLE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .gigMode     (gigMode),
  .txByte      (txByte),
  .txEn        (txEn),
  .txErr       (txErr),
  .txReady     (txReady),
  .txRiseData  (txRiseData),
  .txFallData  (txFallData),
  .txRiseCtl   (txRiseCtl),
  .txFallCtl   (txFallCtl),
  .rxRiseCtl   (rxRiseCtl),
  .rxFallCtl   (rxFallCtl),
  .rxByteValid (rxByteValid),
  .rxErr       (rxErr),
  .rxOob       (rxOob)
);

// File: tb/rgmii_lane_codec_tb.sv
`timescale 1ns/1ps
module rgmii_lane_codec_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       gigMode;
  logic [7:0] txByte;
  logic       txEn;
  logic       txErr;
  logic       txReady;
  logic [3:0] txRiseData;
  logic [3:0] txFallData;
  logic       txRiseCtl;
  logic       txFallCtl;
  logic [3:0] rxRiseData;
  logic [3:0] rxFallData;
  logic       rxRiseCtl;
  logic       rxFallCtl;
  logic [7:0] rxByte;
  logic       rxByteValid;
  logic       rxErr;
  logic       rxOob;
  logic [3:0] rxOobCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rgmii_lane_codec u_dut (
    .clk(clk), .rst(rst), .gigMode(gigMode),
    .txByte(txByte), .txEn(txEn), .txErr(txErr), .txReady(txReady),
    .txRiseData(txRiseData), .txFallData(txFallData),
    .txRiseCtl(txRiseCtl), .txFallCtl(txFallCtl),
    .rxRiseData(rxRiseData), .rxFallData(rxFallData),
    .rxRiseCtl(rxRiseCtl), .rxFallCtl(rxFallCtl),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .rxErr(rxErr),
    .rxOob(rxOob), .rxOobCode(rxOobCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rxIdle();
    rxRiseCtl = 0; rxFallCtl = 0; rxRiseData = 0; rxFallData = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; gigMode = 1; txByte = 8'hA5; txEn = 1; txErr = 1;
    rxRiseData = 4'hF; rxFallData = 4'hF; rxRiseCtl = 1; rxFallCtl = 0;
    step(); step();
    // R11: reset state
    chk("R11 txReady", txReady, 1);
    chk("R11 tx outputs", {txRiseData, txFallData, txRiseCtl, txFallCtl}, 0);
    chk("R11 rx outputs", {rxByte, rxByteValid, rxErr, rxOob, rxOobCode}, 0);
    rst = 0;
    rxIdle();

    // R1/R2: gigabit transmit sweep
    gigMode = 1;
    for (int b = 0; b < 256; b++) begin
      for (int c = 0; c < 4; c++) begin
        txByte = 8'(b); txEn = c[0]; txErr = c[1];
        chk("R1 gig txReady", txReady, 1);
        step();
        chk("R1 gig tx data", {txFallData, txRiseData}, b);
        chk("R2 tx ctl", {txRiseCtl, txFallCtl}, {c[0], c[0] ^ c[1]});
      end
    end

    // R3/R4/R2: 10/100 transmit sweep
    gigMode = 0;
    for (int b = 0; b < 256; b++) begin
      for (int c = 0; c < 4; c++) begin
        txByte = 8'(b); txEn = c[0]; txErr = c[1];
        chk("R3 slow ready first", txReady, 1);
        step();
        chk("R3 slow low nibble", {txRiseData, txFallData}, {b[3:0], b[3:0]});
        chk("R2 slow tx ctl", {txRiseCtl, txFallCtl}, {c[0], c[0] ^ c[1]});
        chk("R3 slow ready second", txReady, 0);
        txByte = ~8'(b); txEn = ~c[0]; txErr = c[0];   // ignored
        step();
        chk("R3 slow high nibble", {txRiseData, txFallData}, {b[7:4], b[7:4]});
        chk("R4 slow ctl held", {txRiseCtl, txFallCtl}, {c[0], c[0] ^ c[1]});
      end
    end

    // R5/R6: gigabit receive sweep
    gigMode = 1;
    for (int b = 0; b < 256; b++) begin
      for (int e = 0; e < 2; e++) begin
        rxRiseCtl = 1; rxFallCtl = 1'(1 - e);
        rxRiseData = b[3:0]; rxFallData = b[7:4];
        step();
        chk("R5 gig rx strobe", rxByteValid, 1);
        chk("R5 gig rx byte", rxByte, b);
        chk("R6 gig rx err", rxErr, e);
        chk("R9 no oob with data", rxOob, 0);
      end
    end

    // R9/R10: out-of-band and idle codes, both modes
    for (int m = 0; m < 2; m++) begin
      gigMode = m[0];
      for (int n = 0; n < 16; n++) begin
        rxRiseCtl = 0; rxFallCtl = 1; rxRiseData = 4'(n); rxFallData = 4'(15 - n);
        step();
        chk("R9 oob strobe", {rxOob, rxByteValid}, 2'b10);
        chk("R9 oob code", rxOobCode, n);
        rxRiseCtl = 0; rxFallCtl = 0;
        step();
        chk("R10 idle quiet", {rxOob, rxByteValid, rxErr}, 0);
      end
    end

    // R7: 10/100 receive sweep, back to back
    gigMode = 0;
    rxIdle();
    step();
    for (int b = 0; b < 256; b++) begin
      rxRiseCtl = 1; rxFallCtl = ~b[0]; rxRiseData = b[3:0]; rxFallData = ~b[7:4];
      step();
      chk("R7 no strobe first clock", rxByteValid, 0);
      rxRiseCtl = 1; rxFallCtl = ~b[1]; rxRiseData = b[7:4]; rxFallData = ~b[3:0];
      step();
      chk("R7 slow rx strobe", rxByteValid, 1);
      chk("R7 slow rx byte", rxByte, b);
      chk("R7 slow rx err", rxErr, int'(b[0] | b[1]));
    end

    // R8: lone half byte dropped by idle
    rxRiseCtl = 1; rxFallCtl = 0; rxRiseData = 4'h3;
    step();
    rxIdle();
    step();
    chk("R8 no strobe on drop", rxByteValid, 0);
    rxRiseCtl = 1; rxFallCtl = 1; rxRiseData = 4'hC;
    step();
    chk("R8 restart no strobe", rxByteValid, 0);
    rxRiseData = 4'h9;
    step();
    chk("R8 restart strobe", rxByteValid, 1);
    chk("R8 restart byte", rxByte, 8'h9C);
    chk("R8 restart no err", rxErr, 0);
    rxIdle();
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule